// File: doc/BRIEF.md
# Power Domain Sequencer

This block brings one switchable power island up or down in a fixed, safe order. It drives the island's reset, its isolation clamp, two stages of power switch, a clock-disable, a group of SRAM power-down lines and a bus-fence request. It decides when to move on from each step by watching two power-good acknowledges, a group of SRAM power-down acknowledges and a bus-fence acknowledge. A short pulse on `reqValid` asks for the island to be on (`reqOn`=1) or off (`reqOn`=0). The block reports the island as off, on, busy or failed.

Every wait for an acknowledge is bounded by `TIMEOUT_CYC` clock cycles. If the bound runs out, the block freezes all of its outputs and reports an error until the next request arrives. The SRAM acknowledge wait and the bus fence are parameter options, so one design serves islands that have neither, one or both. After reset the block powers its island up by itself, so the island and its controller start out in the same state.

Top module: `pwr_dom_seq`

## Requirements
- R1: While reset is held, the outputs are `domRstN`=0, `domIso`=1, `pwrOn`=0, `pwrOn2`=0, `clkDis`=1, `sramPdn` all ones and `busProtReq`=1 (0 when there is no bus fence). After reset is released, the block runs the power-up sequence without any request. `timeoutErr` is 0 outside the error state. `domStat` uses the encoding 00 off, 01 on, 10 busy and 11 error.
- R2: On any clock edge at most one control output changes. The `sramPdn` lines always switch together as one group.
- R3: Power-up raises `pwrOn` and then raises `pwrOn2` on a later edge. It then waits until `pwrAck` and `pwrAck2` are both 1 before it lowers `clkDis`. A mixed pair of acknowledges keeps the block waiting.
- R4: After `clkDis` falls, power-up lowers `domIso`, then raises `domRstN`, then clears all `sramPdn` lines. It then waits until every `sramAck` line reads 0.
- R5: When a bus fence is present, lowering `busProtReq` is the last step of power-up. The block then waits for `busProtAck`=0 and reports on.
- R6: Power-down raises `busProtReq` (when a fence is present) and waits for `busProtAck`=1. It then sets all `sramPdn` lines, waits until every `sramAck` line reads 1, and then raises `domIso`.
- R7: After `domIso` rises, power-down lowers `domRstN`, raises `clkDis`, lowers `pwrOn` and lowers `pwrOn2`, in that order. It waits for both power acknowledges to read 0 and then reports off.
- R8: Suppose a wait starts on the edge that performs the step before it, and its condition stays false. Then `domStat` reads error and `timeoutErr` reads 1 exactly `TIMEOUT_CYC` cycles later. Every control output then stays unchanged until a new request is accepted.
- R9: In the error state, a request in either direction is accepted. Accepting it clears `timeoutErr`, and the block runs that direction's whole sequence from its first step. A step whose output already has the target value produces no change.
- R10: A request that arrives while the block is busy is stored, and only the latest one is kept. The block acts on it once it reaches on, off or error.
- R11: A request for the state the island is already in changes no output and leaves `domStat` unchanged.
- R12: With `HAS_SRAM_ACK`=0 the block never waits on `sramAck`. With `HAS_BUS_PROT`=0, `busProtReq` stays 0 and the block never waits on `busProtAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | One-cycle request strobe |
| reqOn | input | 1 | Requested direction: 1 on, 0 off |
| pwrAck | input | 1 | First power-good acknowledge |
| pwrAck2 | input | 1 | Second power-good acknowledge |
| sramAck | input | ACK_W | SRAM power-down acknowledges |
| busProtAck | input | 1 | Bus-fence acknowledge |
| domRstN | output | 1 | Island reset, active low |
| domIso | output | 1 | Isolation clamp enable |
| pwrOn | output | 1 | First-stage power switch enable |
| pwrOn2 | output | 1 | Second-stage power switch enable |
| clkDis | output | 1 | Island clock disable |
| sramPdn | output | SRAM_W | SRAM power-down controls |
| busProtReq | output | 1 | Bus-fence request |
| domStat | output | 2 | Island status: 00 off, 01 on, 10 busy, 11 error |
| timeoutErr | output | 1 | Wait-timeout error flag |

## Verification
A monitor records every change of the control outputs as a coded event. Each sequence is compared against the exact expected order, so any swapped step, any merged step or any step that moves two outputs at once is reported. The tests freeze one acknowledge at a time: the second power-good, the SRAM group during power-up, and the bus fence during power-down. A design that ignored a mixed power-good pair, released the bus before the SRAM acknowledge, or used the wrong timeout length would show an extra event or a wrong error cycle. Recovery from error checks that steps already at their target value produce no events. A second instance with no SRAM wait and no bus fence has its SRAM acknowledges tied high, so a design that still waited on them would hang and time out. The tests also cover a request made during a sequence and a request for the current state.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [1:0] {
    DS_OFF  = 2'b00,
    DS_ON   = 2'b01,
    DS_BUSY = 2'b10,
    DS_ERR  = 2'b11
  } domStat_e;

  typedef enum logic [2:0] {
    SEL_PWR1, SEL_PWR2, SEL_CLK, SEL_ISO, SEL_RST, SEL_SRAM, SEL_BUS
  } ctlSel_e;

  // One strobe set per cycle from the sequencer to the control-word datapath.
  typedef struct packed {
    logic    wrEn;
    ctlSel_e sel;
    logic    val;
    logic    tmrRun;
  } ctlStrb_t;

  typedef enum logic [4:0] {
    ST_OFF, ST_ON, ST_ERR,
    U_PWR1, U_PWR2, U_WPWR, U_CLK, U_ISO, U_RST, U_SRAM, U_WSRAM, U_BUS, U_WBUS,
    D_BUS, D_WBUS, D_SRAM, D_WSRAM, D_ISO, D_RST, D_CLK, D_PWR1, D_PWR2, D_WPWR
  } seqSt_e;

endpackage

// File: rtl/pds_ctrl.sv
module pds_ctrl
  import pds_pkg::*;
#(
  parameter bit HAS_SRAM_ACK = 1'b1,
  parameter bit HAS_BUS_PROT = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  input  logic     reqOn,
  input  logic     pwrUp,
  input  logic     pwrDown,
  input  logic     sramClr,
  input  logic     sramSet,
  input  logic     busAck,
  input  logic     tmrExp,
  output ctlStrb_t strb,
  output logic [1:0] domStat,
  output logic     timeoutErr
);

  localparam seqSt_e FIRST_DOWN = HAS_BUS_PROT ? D_BUS : D_SRAM;
  localparam seqSt_e UP_TAIL    = HAS_BUS_PROT ? U_BUS : ST_ON;

  seqSt_e st, nxt;
  logic   pend, pendOn, stable, take;

  assign stable = (st == ST_OFF) || (st == ST_ON) || (st == ST_ERR);
  assign take   = stable && pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      pendOn <= 1'b0;
    end else if (reqValid) begin
      pend   <= 1'b1;
      pendOn <= reqOn;
    end else if (take) begin
      pend   <= 1'b0;
    end
  end

  function automatic ctlStrb_t wr(input ctlSel_e s, input logic v);
    ctlStrb_t r;
    r.wrEn = 1'b1; r.sel = s; r.val = v; r.tmrRun = 1'b0;
    return r;
  endfunction

  always_comb begin
    nxt  = st;
    strb = '0;
    unique case (st)
      ST_OFF:  if (take && pendOn)  nxt = U_PWR1;
      ST_ON:   if (take && !pendOn) nxt = FIRST_DOWN;
      ST_ERR:  if (take)            nxt = pendOn ? U_PWR1 : FIRST_DOWN;
      U_PWR1:  begin strb = wr(SEL_PWR1, 1'b1); nxt = U_PWR2; end
      U_PWR2:  begin strb = wr(SEL_PWR2, 1'b1); nxt = U_WPWR; end
      U_WPWR:  begin
        strb.tmrRun = 1'b1;
        if (pwrUp) nxt = U_CLK; else if (tmrExp) nxt = ST_ERR;
      end
      U_CLK:   begin strb = wr(SEL_CLK, 1'b0); nxt = U_ISO; end
      U_ISO:   begin strb = wr(SEL_ISO, 1'b0); nxt = U_RST; end
      U_RST:   begin strb = wr(SEL_RST, 1'b1); nxt = U_SRAM; end
      U_SRAM:  begin strb = wr(SEL_SRAM, 1'b0); nxt = HAS_SRAM_ACK ? U_WSRAM : UP_TAIL; end
      U_WSRAM: begin
        strb.tmrRun = 1'b1;
        if (sramClr) nxt = UP_TAIL; else if (tmrExp) nxt = ST_ERR;
      end
      U_BUS:   begin strb = wr(SEL_BUS, 1'b0); nxt = U_WBUS; end
      U_WBUS:  begin
        strb.tmrRun = 1'b1;
        if (!busAck) nxt = ST_ON; else if (tmrExp) nxt = ST_ERR;
      end
      D_BUS:   begin strb = wr(SEL_BUS, 1'b1); nxt = D_WBUS; end
      D_WBUS:  begin
        strb.tmrRun = 1'b1;
        if (busAck) nxt = D_SRAM; else if (tmrExp) nxt = ST_ERR;
      end
      D_SRAM:  begin strb = wr(SEL_SRAM, 1'b1); nxt = HAS_SRAM_ACK ? D_WSRAM : D_ISO; end
      D_WSRAM: begin
        strb.tmrRun = 1'b1;
        if (sramSet) nxt = D_ISO; else if (tmrExp) nxt = ST_ERR;
      end
      D_ISO:   begin strb = wr(SEL_ISO, 1'b1); nxt = D_RST; end
      D_RST:   begin strb = wr(SEL_RST, 1'b0); nxt = D_CLK; end
      D_CLK:   begin strb = wr(SEL_CLK, 1'b1); nxt = D_PWR1; end
      D_PWR1:  begin strb = wr(SEL_PWR1, 1'b0); nxt = D_PWR2; end
      D_PWR2:  begin strb = wr(SEL_PWR2, 1'b0); nxt = D_WPWR; end
      D_WPWR:  begin
        strb.tmrRun = 1'b1;
        if (pwrDown) nxt = ST_OFF; else if (tmrExp) nxt = ST_ERR;
      end
      default: nxt = ST_ERR;
    endcase
  end

  // Reset lands directly on the first power-up step: the island comes up unasked.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= U_PWR1;
    else        st <= nxt;
  end

  always_comb begin
    unique case (st)
      ST_OFF:  domStat = DS_OFF;
      ST_ON:   domStat = DS_ON;
      ST_ERR:  domStat = DS_ERR;
      default: domStat = DS_BUSY;
    endcase
  end
  assign timeoutErr = (st == ST_ERR);

  // R10: a request seen while busy stays pending until a stable state.
  a_r10_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !stable && !reqValid) |=> pend)
    else $error("a_r10_pend_held");

endmodule

// File: rtl/pds_dpath.sv
module pds_dpath
  import pds_pkg::*;
#(
  parameter int SRAM_W      = 4,
  parameter int ACK_W       = 4,
  parameter int TIMEOUT_CYC = 1024,
  parameter bit HAS_SRAM_ACK = 1'b1,
  parameter bit HAS_BUS_PROT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrb_t          strb,
  input  logic              pwrAck,
  input  logic              pwrAck2,
  input  logic [ACK_W-1:0]  sramAck,
  output logic              rstNQ,
  output logic              isoQ,
  output logic              pwr1Q,
  output logic              pwr2Q,
  output logic              clkDisQ,
  output logic [SRAM_W-1:0] sramQ,
  output logic              busQ,
  output logic              pwrUp,
  output logic              pwrDown,
  output logic              sramClr,
  output logic              sramSet,
  output logic              tmrExp
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstNQ   <= 1'b0;
      isoQ    <= 1'b1;
      pwr1Q   <= 1'b0;
      pwr2Q   <= 1'b0;
      clkDisQ <= 1'b1;
      sramQ   <= '1;
    end else if (strb.wrEn) begin
      unique case (strb.sel)
        SEL_PWR1: pwr1Q   <= strb.val;
        SEL_PWR2: pwr2Q   <= strb.val;
        SEL_CLK:  clkDisQ <= strb.val;
        SEL_ISO:  isoQ    <= strb.val;
        SEL_RST:  rstNQ   <= strb.val;
        SEL_SRAM: sramQ   <= {SRAM_W{strb.val}};
        default:  ;
      endcase
    end
  end

  generate
    if (HAS_BUS_PROT) begin : g_bus
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  busQ <= 1'b1;
        else if (strb.wrEn && strb.sel == SEL_BUS)   busQ <= strb.val;
      end
    end else begin : g_nobus
      assign busQ = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tmr <= '0;
    else if (!strb.tmrRun) tmr <= '0;
    else                   tmr <= tmr + TW'(1);
  end

  assign tmrExp  = strb.tmrRun && (tmr == TW'(TIMEOUT_CYC - 1));
  assign pwrUp   = pwrAck && pwrAck2;
  assign pwrDown = !pwrAck && !pwrAck2;
  assign sramClr = (sramAck == '0);
  assign sramSet = (sramAck == '1);

  logic [6:0] ctlWord;
  assign ctlWord = {busQ, sramQ[0], clkDisQ, pwr2Q, pwr1Q, isoQ, rstNQ};

  a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ctlWord ^ $past(ctlWord)) <= 1)
    else $error("a_r2_one_step");

  a_r3_clk_after_pwr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clkDisQ) |-> (pwr1Q && pwr2Q && pwrAck && pwrAck2))
    else $error("a_r3_clk_after_pwr");

  a_r4_rst_after_iso: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstNQ) |-> (!isoQ && !clkDisQ))
    else $error("a_r4_rst_after_iso");

  a_r5_bus_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busQ) |-> (rstNQ && sramQ == '0 && (!HAS_SRAM_ACK || sramAck == '0)))
    else $error("a_r5_bus_last");

  a_r6_iso_after_sram: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isoQ) |-> ((&sramQ) && (!HAS_SRAM_ACK || (&sramAck)) && (!HAS_BUS_PROT || busQ)))
    else $error("a_r6_iso_after_sram");

  a_r7_pwr_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr1Q) |-> (!rstNQ && isoQ && clkDisQ))
    else $error("a_r7_pwr_drop");

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pds_pkg::*;
#(
  parameter int SRAM_W       = 4,
  parameter int ACK_W        = 4,
  parameter int TIMEOUT_CYC  = 1024,
  parameter bit HAS_SRAM_ACK = 1'b1,
  parameter bit HAS_BUS_PROT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqOn,
  input  logic              pwrAck,
  input  logic              pwrAck2,
  input  logic [ACK_W-1:0]  sramAck,
  input  logic              busProtAck,
  output logic              domRstN,
  output logic              domIso,
  output logic              pwrOn,
  output logic              pwrOn2,
  output logic              clkDis,
  output logic [SRAM_W-1:0] sramPdn,
  output logic              busProtReq,
  output logic [1:0]        domStat,
  output logic              timeoutErr
);

  ctlStrb_t strb;
  logic pwrUp, pwrDown, sramClr, sramSet, tmrExp;

  pds_ctrl #(
    .HAS_SRAM_ACK(HAS_SRAM_ACK),
    .HAS_BUS_PROT(HAS_BUS_PROT)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOn(reqOn),
    .pwrUp(pwrUp), .pwrDown(pwrDown), .sramClr(sramClr), .sramSet(sramSet),
    .busAck(busProtAck), .tmrExp(tmrExp), .strb(strb),
    .domStat(domStat), .timeoutErr(timeoutErr)
  );

  pds_dpath #(
    .SRAM_W(SRAM_W), .ACK_W(ACK_W), .TIMEOUT_CYC(TIMEOUT_CYC),
    .HAS_SRAM_ACK(HAS_SRAM_ACK), .HAS_BUS_PROT(HAS_BUS_PROT)
  ) i_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .pwrAck(pwrAck), .pwrAck2(pwrAck2), .sramAck(sramAck),
    .rstNQ(domRstN), .isoQ(domIso), .pwr1Q(pwrOn), .pwr2Q(pwrOn2),
    .clkDisQ(clkDis), .sramQ(sramPdn), .busQ(busProtReq),
    .pwrUp(pwrUp), .pwrDown(pwrDown), .sramClr(sramClr), .sramSet(sramSet),
    .tmrExp(tmrExp)
  );

  // R8: once in error and still in error, every control output is frozen.
  a_r8_err_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (domStat == DS_ERR && $past(domStat) == DS_ERR) |->
      $stable({domRstN, domIso, pwrOn, pwrOn2, clkDis, sramPdn, busProtReq}))
    else $error("a_r8_err_frozen");

endmodule

// File: tb/test_pwr_dom_seq.sv
`timescale 1ns/1ps
module test_pwr_dom_seq;

  localparam int SRAM_W = 4;
  localparam int ACK_W  = 4;
  localparam int TMO    = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // main instance
  logic reqValid = 1'b0, reqOn = 1'b0;
  logic pwrAck = 1'b0, pwrAck2 = 1'b0, busProtAck = 1'b0;
  logic [ACK_W-1:0] sramAck = '0;
  logic domRstN, domIso, pwrOn, pwrOn2, clkDis, busProtReq, timeoutErr;
  logic [SRAM_W-1:0] sramPdn;
  logic [1:0] domStat;

  pwr_dom_seq #(.SRAM_W(SRAM_W), .ACK_W(ACK_W), .TIMEOUT_CYC(TMO),
                .HAS_SRAM_ACK(1'b1), .HAS_BUS_PROT(1'b1)) i_pwr_dom_seq (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOn(reqOn),
    .pwrAck(pwrAck), .pwrAck2(pwrAck2), .sramAck(sramAck), .busProtAck(busProtAck),
    .domRstN(domRstN), .domIso(domIso), .pwrOn(pwrOn), .pwrOn2(pwrOn2),
    .clkDis(clkDis), .sramPdn(sramPdn), .busProtReq(busProtReq),
    .domStat(domStat), .timeoutErr(timeoutErr));

  // reduced instance: no SRAM wait, no bus fence; SRAM acks stuck high
  logic lReqValid = 1'b0, lReqOn = 1'b0, lAck1 = 1'b0, lAck2 = 1'b0;
  logic lRstN, lIso, lPwrOn, lPwrOn2, lClkDis, lBus, lErr;
  logic [SRAM_W-1:0] lSram;
  logic [1:0] lStat;
  logic liteBusSeen = 1'b0;

  pwr_dom_seq #(.SRAM_W(SRAM_W), .ACK_W(ACK_W), .TIMEOUT_CYC(TMO),
                .HAS_SRAM_ACK(1'b0), .HAS_BUS_PROT(1'b0)) i_pwr_dom_seq_lite (
    .clk(clk), .rst_n(rst_n), .reqValid(lReqValid), .reqOn(lReqOn),
    .pwrAck(lAck1), .pwrAck2(lAck2), .sramAck({ACK_W{1'b1}}), .busProtAck(1'b0),
    .domRstN(lRstN), .domIso(lIso), .pwrOn(lPwrOn), .pwrOn2(lPwrOn2),
    .clkDis(lClkDis), .sramPdn(lSram), .busProtReq(lBus),
    .domStat(lStat), .timeoutErr(lErr));

  // acknowledge responders with a 3-cycle lag; each can be frozen
  logic hold2 = 1'b0, holdS = 1'b0, holdB = 1'b0;
  logic [2:0] p1 = '0, p2 = '0, ps = '0, pb = '0;
  always @(negedge clk) begin
    p1 <= {p1[1:0], pwrOn};
    p2 <= {p2[1:0], pwrOn2};
    ps <= {ps[1:0], &sramPdn};
    pb <= {pb[1:0], busProtReq};
    pwrAck <= p1[2];
    if (!hold2) pwrAck2    <= p2[2];
    if (!holdS) sramAck    <= {ACK_W{ps[2]}};
    if (!holdB) busProtAck <= pb[2];
    lAck1 <= lPwrOn;
    lAck2 <= lPwrOn2;
    if (rst_n && lBus) liteBusSeen <= 1'b1;
  end

  // event monitor: codes 1..7 power-up steps, 8..14 power-down steps, 15 illegal
  logic [63:0] evLog = '0;
  int evCnt = 0;
  logic [6:0] prevW = '0, curW;
  int nc;

  task automatic push(input logic [3:0] c);
    evLog = {evLog[59:0], c};
    evCnt++;
  endtask

  always @(negedge clk) begin
    curW = {busProtReq, sramPdn[0], clkDis, pwrOn2, pwrOn, domIso, domRstN};
    if (!rst_n) prevW = curW;
    else begin
      nc = 0;
      if (curW[2] !== prevW[2]) begin push(curW[2] ? 4'd1  : 4'd13); nc++; end
      if (curW[3] !== prevW[3]) begin push(curW[3] ? 4'd2  : 4'd14); nc++; end
      if (curW[4] !== prevW[4]) begin push(curW[4] ? 4'd12 : 4'd3);  nc++; end
      if (curW[1] !== prevW[1]) begin push(curW[1] ? 4'd10 : 4'd4);  nc++; end
      if (curW[0] !== prevW[0]) begin push(curW[0] ? 4'd5  : 4'd11); nc++; end
      if (curW[5] !== prevW[5]) begin push(curW[5] ? 4'd9  : 4'd6);  nc++; end
      if (curW[6] !== prevW[6]) begin push(curW[6] ? 4'd8  : 4'd7);  nc++; end
      if (nc > 1) push(4'd15);
      if (sramPdn != '0 && sramPdn != '1) push(4'd15);
      prevW = curW;
    end
  end

  int nChk = 0, nFail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clrLog();
    evLog = '0;
    evCnt = 0;
  endtask

  task automatic chkLog(input string tag, input logic [63:0] expLog, input int expCnt);
    chk({tag, " events"}, evLog, expLog);
    chk({tag, " event count"}, 64'(evCnt), 64'(expCnt));
  endtask

  task automatic sendReq(input logic on);
    @(negedge clk); reqValid = 1'b1; reqOn = on;
    @(negedge clk); reqValid = 1'b0;
  endtask

  task automatic waitStat(input logic [1:0] tgt, input int lim, input string tag);
    int n = 0;
    do begin @(negedge clk); n++; end while (domStat !== tgt && n < lim);
    chk({tag, " status"}, 64'(domStat), 64'(tgt));
  endtask

  // R1: reset values, then unprompted power-up
  task automatic t_reset_boot();
    repeat (3) @(negedge clk);
    chk("R1 reset outputs",
        {57'd0, domRstN, domIso, pwrOn, pwrOn2, clkDis, busProtReq, timeoutErr},
        {57'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0});
    chk("R1 reset sram", 64'(sramPdn), 64'hF);
    rst_n = 1'b1;
    waitStat(2'b01, 200, "R1 boot");
    chkLog("R3 R4 R5 power-up order", 64'h1234567, 7);
    chk("R1 no error after boot", 64'(timeoutErr), 64'd0);
  endtask

  // R6 R7: full power-down order
  task automatic t_power_off();
    clrLog();
    sendReq(1'b0);
    waitStat(2'b00, 200, "R7 off");
    chkLog("R6 R7 power-down order", 64'h89ABCDE, 7);
  endtask

  // R11: request for the current state
  task automatic t_redundant();
    clrLog();
    sendReq(1'b0);
    repeat (20) @(negedge clk);
    chkLog("R11 redundant request", 64'h0, 0);
    chk("R11 status kept", 64'(domStat), 64'd0);
  endtask

  // R10: request during a sequence is held
  task automatic t_held();
    clrLog();
    sendReq(1'b1);
    repeat (4) @(negedge clk);
    sendReq(1'b0);
    waitStat(2'b00, 400, "R10 held");
    chkLog("R10 up then down", 64'h123456789ABCDE, 14);
  endtask

  // R8 R3: second power-good frozen low, exact timeout cycle
  task automatic t_pwr_timeout();
    int n = 0;
    hold2 = 1'b1;
    clrLog();
    sendReq(1'b1);
    do @(negedge clk); while (pwrOn2 !== 1'b1);
    do begin @(negedge clk); n++; end while (domStat !== 2'b11 && n < TMO + 20);
    chk("R8 timeout cycle", 64'(n), 64'(TMO));
    chk("R8 error flag", 64'(timeoutErr), 64'd1);
    repeat (10) @(negedge clk);
    chkLog("R8 R3 frozen after mixed acks", 64'h12, 2);
    hold2 = 1'b0;
  endtask

  // R9: leave error with an off request
  task automatic t_recover_off();
    repeat (6) @(negedge clk);
    clrLog();
    sendReq(1'b0);
    waitStat(2'b00, 200, "R9 recover off");
    chk("R9 error cleared", 64'(timeoutErr), 64'd0);
    chkLog("R9 only pending steps", 64'hDE, 2);
  endtask

  // R4: SRAM acks stuck high during power-up; bus not released
  task automatic t_sram_timeout();
    holdS = 1'b1;
    clrLog();
    sendReq(1'b1);
    waitStat(2'b11, 200, "R4 sram wait timeout");
    repeat (5) @(negedge clk);
    chkLog("R4 bus held until sram ack", 64'h123456, 6);
    chk("R5 bus fence still on", 64'(busProtReq), 64'd1);
    holdS = 1'b0;
    repeat (6) @(negedge clk);
    clrLog();
    sendReq(1'b1);
    waitStat(2'b01, 200, "R9 recover on");
    chkLog("R9 R5 bus release only", 64'h7, 1);
  endtask

  // R6: bus fence ack frozen low during power-down
  task automatic t_bus_timeout();
    holdB = 1'b1;
    clrLog();
    sendReq(1'b0);
    waitStat(2'b11, 200, "R6 bus wait timeout");
    chkLog("R6 only fence raised", 64'h8, 1);
    chk("R6 sram untouched", 64'(sramPdn), 64'h0);
    holdB = 1'b0;
    repeat (6) @(negedge clk);
    clrLog();
    sendReq(1'b1);
    waitStat(2'b01, 200, "R9 recover from fence");
    chkLog("R9 fence dropped", 64'h7, 1);
  endtask

  // R12: reduced instance skips SRAM wait and has no fence
  task automatic t_lite();
    int n = 0;
    chk("R12 lite on after boot", 64'(lStat), 64'd1);
    chk("R12 lite sram cleared", 64'(lSram), 64'h0);
    @(negedge clk); lReqValid = 1'b1; lReqOn = 1'b0;
    @(negedge clk); lReqValid = 1'b0;
    do begin @(negedge clk); n++; end while (lStat !== 2'b00 && n < 200);
    chk("R12 lite off", 64'(lStat), 64'd0);
    chk("R12 lite power dropped", {62'd0, lPwrOn, lPwrOn2}, 64'd0);
    chk("R12 lite fence never raised", 64'(liteBusSeen), 64'd0);
  endtask

  initial begin
    t_reset_boot();
    t_power_off();
    t_redundant();
    t_held();
    t_pwr_timeout();
    t_recover_off();
    t_sram_timeout();
    t_bus_timeout();
    t_lite();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule